// File: doc/BRIEF.md
# Audio Codec Control Register File

This block holds the control settings of an audio codec and takes them in over a three-wire serial write port. The serial clock, chip select and data lines are sampled in the system clock domain. Each frame carries one 16-bit control word, sent most significant bit first. The upper seven bits of the word select a register and the lower nine bits are the new contents.

Ten registers hold settings at addresses 0 to 9. Address 15 is a reset register: writing to it returns the whole bank to its defaults. The line-input pair sits at addresses 0 and 1, and the headphone pair sits at addresses 2 and 3. A write to either register of a pair can also load its shared fields into the other channel.

The block decodes these pairs into per-channel gain codes, mute flags and zero-cross enables. The headphone mute output also covers the band of low volume codes that silences the channel. A combinational read port lets the bench inspect any address.

Top module: `codec_ctl_regs`

## Requirements
- R1: A frame runs from the falling to the rising edge of `csn_i`. Data is taken from `sdi_i` on each rising edge of `sclk_i` while `csn_i` is low, first bit = word bit 15. Bits 15:9 are the address and bits 8:0 are the data. The word takes effect when `csn_i` rises, and at most one write happens per frame.
- R2: A frame with a bit count other than 16 (for example 15 or 17) changes no register.
- R3: After reset, addresses 0 and 1 read 0x097 (volume 10111, mute bit 7 set), addresses 2 and 3 read 0x079 (volume 1111001), and every other address reads 0x000.
- R4: A write to an address in 0 to 9 stores all nine data bits there, and the read port returns them.
- R5: A write to address 0 or 1 with bit 8 set also copies data bits 4:0 and bit 7 into the other line-input register. All other bits of that other register are left unchanged.
- R6: A write to address 2 or 3 with bit 8 set also copies data bits 7:0 into the other headphone register. Bit 8 of that other register is left unchanged.
- R7: A write with bit 8 clear leaves the other register of the pair unchanged.
- R8: Any write to address 15 restores every register to its R3 default value.
- R9: Writes to addresses 10 to 14 and 16 to 127 change no register.
- R10: The line gain outputs show bits 4:0 of registers 0 and 1, and the line mute outputs show bit 7 of those registers. The headphone gain outputs show bits 6:0 of registers 2 and 3, and the zero-cross outputs show bit 7 of those registers.
- R11: A headphone mute output is high when that channel's volume code is 0x2F or below, and low when it is 0x30 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock |
| csn_i | input | 1 | Serial frame select, active low |
| sdi_i | input | 1 | Serial data in |
| rd_addr_i | input | 7 | Read-back address |
| rd_data_o | output | 9 | Read-back data (0 for unstored addresses) |
| line_l_gain_o | output | 5 | Left line-input gain code |
| line_r_gain_o | output | 5 | Right line-input gain code |
| line_l_mute_o | output | 1 | Left line-input mute |
| line_r_mute_o | output | 1 | Right line-input mute |
| hp_l_gain_o | output | 7 | Left headphone gain code |
| hp_r_gain_o | output | 7 | Right headphone gain code |
| hp_l_mute_o | output | 1 | Left headphone effective mute |
| hp_r_mute_o | output | 1 | Right headphone effective mute |
| hp_l_zc_o | output | 1 | Left headphone zero-cross enable |
| hp_r_zc_o | output | 1 | Right headphone zero-cross enable |

## Verification
Writes are sent to each pair with the link bit set and with it clear, and in both directions. The target register is first loaded with values that differ from the source in the masked-out bits, so a copy mask that is too wide or too narrow shows up. Headphone volumes of 0x2F and 0x30 are written to pin down the mute threshold by one code. Frames of 15 and 17 bits, and writes to unstored addresses in both the 10 to 14 band and the band above the reset register, are compared against a full read-back of the bank. A write to the reset register after all of this shows that every register returns to its default.

// File: rtl/codec_ctl_pkg.sv
`timescale 1ns/1ps
package codec_ctl_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = WORD_W - ADDR_W;
  localparam int NREG       = 10;
  localparam int RESET_ADDR = 15;
  localparam int LINK_BIT   = 8;
  localparam int LINE_VOL_W = 5;
  localparam int HP_VOL_W   = 7;
  localparam int FLAG_BIT   = 7;

  localparam logic [DATA_W-1:0] LINE_LINK_MASK = 9'h09F;
  localparam logic [DATA_W-1:0] HP_LINK_MASK   = 9'h0FF;
  localparam logic [HP_VOL_W-1:0] HP_MUTE_TOP  = 7'h2F;

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    case (idx)
      0, 1:    return 9'h097;
      2, 3:    return 9'h079;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ctl_serial_rx.sv
`timescale 1ns/1ps
module ctl_serial_rx
  import codec_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              wr_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic sclk_s1, sclk_s2, csn_s1, csn_s2, sdi_s1;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;

  wire sclk_rise = sclk_s1 & ~sclk_s2;
  wire csn_rise  = csn_s1 & ~csn_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s1 <= 1'b0;
      sclk_s2 <= 1'b0;
      csn_s1  <= 1'b1;
      csn_s2  <= 1'b1;
      sdi_s1  <= 1'b0;
    end else begin
      sclk_s1 <= sclk_i;
      sclk_s2 <= sclk_s1;
      csn_s1  <= csn_i;
      csn_s2  <= csn_s1;
      sdi_s1  <= sdi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shreg_q  <= '0;
      wr_vld_o <= 1'b0;
    end else begin
      wr_vld_o <= csn_rise && (cnt_q == CNT_FULL);
      if (csn_s1) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[WORD_W-2:0], sdi_s1};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o = shreg_q;

  // one strobe per frame: never two in a row
  assert_single_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |=> !wr_vld_o);
endmodule

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank
  import codec_ctl_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_vld_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_ADDR);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(NREG);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  wire soft_rst = wr_vld_i && (wr_addr_i == RST_A);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(g);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(g ^ 1);
    localparam logic [DATA_W-1:0] LINK_M = (g < 2) ? LINE_LINK_MASK :
                                           (g < 4) ? HP_LINK_MASK : '0;
    logic hit, mirror;
    assign hit    = wr_vld_i && (wr_addr_i == OWN_A);
    assign mirror = wr_vld_i && (LINK_M != '0) && wr_data_i[LINK_BIT] &&
                    (wr_addr_i == PEER_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[g] <= reg_default(g);
      else if (soft_rst) regs_q[g] <= reg_default(g);
      else if (hit)    regs_q[g] <= wr_data_i;
      else if (mirror) regs_q[g] <= (regs_q[g] & ~LINK_M) | (wr_data_i & LINK_M);
    end
  end

  assign regs_o = regs_q;

  assert_unmapped_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && wr_addr_i >= TOP_A && wr_addr_i != RST_A) |=> $stable(regs_q));

  assert_soft_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (regs_q[0] == reg_default(0)) && (regs_q[2] == reg_default(2)));

  assert_line_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && wr_addr_i == '0 && wr_data_i[LINK_BIT]) |=>
      (regs_q[1][LINE_VOL_W-1:0] == $past(wr_data_i[LINE_VOL_W-1:0])) &&
      (regs_q[1][FLAG_BIT] == $past(wr_data_i[FLAG_BIT])));
endmodule

// File: rtl/ctl_out_decode.sv
`timescale 1ns/1ps
module ctl_out_decode
  import codec_ctl_pkg::*;
(
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  output logic [LINE_VOL_W-1:0]       line_gain_o [2],
  output logic [1:0]                  line_mute_o,
  output logic [HP_VOL_W-1:0]         hp_gain_o [2],
  output logic [1:0]                  hp_mute_o,
  output logic [1:0]                  hp_zc_o
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign line_gain_o[c] = regs_i[c][LINE_VOL_W-1:0];
    assign line_mute_o[c] = regs_i[c][FLAG_BIT];
    assign hp_gain_o[c]   = regs_i[2+c][HP_VOL_W-1:0];
    assign hp_zc_o[c]     = regs_i[2+c][FLAG_BIT];
    // low volume band silences the output
    assign hp_mute_o[c]   = regs_i[2+c][HP_VOL_W-1:0] <= HP_MUTE_TOP;
  end
endmodule

// File: rtl/codec_ctl_regs.sv
`timescale 1ns/1ps
module codec_ctl_regs
  import codec_ctl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  csn_i,
  input  logic                  sdi_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [LINE_VOL_W-1:0] line_l_gain_o,
  output logic [LINE_VOL_W-1:0] line_r_gain_o,
  output logic                  line_l_mute_o,
  output logic                  line_r_mute_o,
  output logic [HP_VOL_W-1:0]   hp_l_gain_o,
  output logic [HP_VOL_W-1:0]   hp_r_gain_o,
  output logic                  hp_l_mute_o,
  output logic                  hp_r_mute_o,
  output logic                  hp_l_zc_o,
  output logic                  hp_r_zc_o
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [ADDR_W-1:0] HPL_A = ADDR_W'(2);

  logic                        wr_vld;
  logic [WORD_W-1:0]           word;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [LINE_VOL_W-1:0]       line_gain [2];
  logic [HP_VOL_W-1:0]         hp_gain [2];
  logic [1:0]                  line_mute, hp_mute, hp_zc;

  wire [ADDR_W-1:0] wr_addr = word[WORD_W-1:DATA_W];
  wire [DATA_W-1:0] wr_data = word[DATA_W-1:0];

  ctl_serial_rx u_rx (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .sdi_i,
    .wr_vld_o (wr_vld),
    .word_o   (word)
  );

  ctl_reg_bank u_bank (
    .clk_i, .rst_ni,
    .wr_vld_i  (wr_vld),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  ctl_out_decode u_dec (
    .regs_i      (regs),
    .line_gain_o (line_gain),
    .line_mute_o (line_mute),
    .hp_gain_o   (hp_gain),
    .hp_mute_o   (hp_mute),
    .hp_zc_o     (hp_zc)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NREG)) rd_data_o = regs[rd_addr_i[IDX_W-1:0]];
  end

  assign line_l_gain_o = line_gain[0];
  assign line_r_gain_o = line_gain[1];
  assign line_l_mute_o = line_mute[0];
  assign line_r_mute_o = line_mute[1];
  assign hp_l_gain_o   = hp_gain[0];
  assign hp_r_gain_o   = hp_gain[1];
  assign hp_l_mute_o   = hp_mute[0];
  assign hp_r_mute_o   = hp_mute[1];
  assign hp_l_zc_o     = hp_zc[0];
  assign hp_r_zc_o     = hp_zc[1];

  assert_hp_low_band_mute_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld && wr_addr == HPL_A && wr_data[HP_VOL_W-1:0] <= HP_MUTE_TOP) |=> hp_l_mute_o);

  assert_hp_audible_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld && wr_addr == HPL_A && wr_data[HP_VOL_W-1:0] > HP_MUTE_TOP) |=> !hp_l_mute_o);
endmodule

// File: tb/codec_ctl_regs_tb.sv
`timescale 1ns/1ps
module codec_ctl_regs_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [8:0] rd_data;
  logic [4:0] line_l_gain, line_r_gain;
  logic [6:0] hp_l_gain, hp_r_gain;
  logic line_l_mute, line_r_mute, hp_l_mute, hp_r_mute, hp_l_zc, hp_r_zc;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q [16];

  always #2.5 clk = ~clk;

  codec_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .line_l_gain_o(line_l_gain), .line_r_gain_o(line_r_gain),
    .line_l_mute_o(line_l_mute), .line_r_mute_o(line_r_mute),
    .hp_l_gain_o(hp_l_gain), .hp_r_gain_o(hp_r_gain),
    .hp_l_mute_o(hp_l_mute), .hp_r_mute_o(hp_r_mute),
    .hp_l_zc_o(hp_l_zc), .hp_r_zc_o(hp_r_zc)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < 16; i++) exp_q[i] = '0;
    exp_q[0] = 9'h097; exp_q[1] = 9'h097;
    exp_q[2] = 9'h079; exp_q[3] = 9'h079;
  endtask

  // expected-state model built from R4..R9
  task automatic model_write(logic [6:0] a, logic [8:0] d);
    if (a == 7'd15) model_defaults();
    else if (a < 7'd10) begin
      exp_q[a] = d;
      if (d[8] && a < 7'd2)
        exp_q[a ^ 7'd1] = (exp_q[a ^ 7'd1] & 9'h160) | (d & 9'h09F);
      else if (d[8] && a < 7'd4)
        exp_q[a ^ 7'd1] = (exp_q[a ^ 7'd1] & 9'h100) | (d & 9'h0FF);
    end
  endtask

  task automatic send_bits(logic [16:0] w, int nbits);
    csn = 1'b0;
    #20;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
    end
    #20 csn = 1'b1;
    #60;
  endtask

  task automatic write_reg(logic [6:0] a, logic [8:0] d);
    send_bits({1'b0, a, d}, 16);
    model_write(a, d);
  endtask

  task automatic check_bank(string req);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 7'(i);
      #2;
      check(req, 16'(rd_data), 16'(exp_q[i]));
    end
  endtask

  task automatic t_reset();
    model_defaults();
    check_bank("R3");
    check("R10", 16'(line_l_gain), 16'h17);
    check("R10", 16'({line_l_mute, line_r_mute}), 16'h3);
    check("R10", 16'(hp_r_gain), 16'h79);
    check("R11", 16'({hp_l_mute, hp_r_mute}), 16'h0);
    check("R10", 16'({hp_l_zc, hp_r_zc}), 16'h0);
  endtask

  task automatic t_plain();
    write_reg(7'd0, 9'h01F);
    check_bank("R1 R4 R7");
    check("R10", 16'({line_l_gain, line_l_mute}), 16'({5'h1F, 1'b0}));
    check("R7", 16'({line_r_gain, line_r_mute}), 16'({5'h17, 1'b1}));
    write_reg(7'd5, 9'h1A5);
    rd_addr = 7'd5; #2;
    check("R4", 16'(rd_data), 16'h1A5);
  endtask

  task automatic t_linked_line();
    write_reg(7'd1, 9'h1C3);
    rd_addr = 7'd0; #2;
    check("R5", 16'(rd_data), 16'h083);
    write_reg(7'd0, 9'h105);
    rd_addr = 7'd1; #2;
    check("R5", 16'(rd_data), 16'h145);
    check("R10", 16'({line_r_gain, line_r_mute}), 16'({5'h05, 1'b0}));
  endtask

  task automatic t_linked_hp();
    write_reg(7'd2, 9'h1A0);
    rd_addr = 7'd3; #2;
    check("R6", 16'(rd_data), 16'h0A0);
    check("R10", 16'({hp_r_gain, hp_r_zc}), 16'({7'h20, 1'b1}));
    check("R11", 16'(hp_r_mute), 16'h1);
    write_reg(7'd3, 9'h17F);
    rd_addr = 7'd2; #2;
    check("R6", 16'(rd_data), 16'h17F);
    check("R11", 16'(hp_l_mute), 16'h0);
  endtask

  task automatic t_hp_boundary();
    write_reg(7'd3, 9'h02F);
    check("R11", 16'(hp_r_mute), 16'h1);
    rd_addr = 7'd2; #2;
    check("R7", 16'(rd_data), 16'h17F);
    write_reg(7'd3, 9'h030);
    check("R11", 16'(hp_r_mute), 16'h0);
    write_reg(7'd2, 9'h02F);
    check("R11", 16'(hp_l_mute), 16'h1);
    write_reg(7'd2, 9'h030);
    check("R11", 16'(hp_l_mute), 16'h0);
  endtask

  task automatic t_bad_frames();
    send_bits({1'b0, 7'd4, 9'h155}, 15);
    send_bits({7'd4, 9'h0AA, 1'b1}, 17);
    send_bits({1'b0, 7'd4, 9'h155}, 1);
    check_bank("R2");
    write_reg(7'd4, 9'h155);
    rd_addr = 7'd4; #2;
    check("R1", 16'(rd_data), 16'h155);
  endtask

  task automatic t_unmapped();
    send_bits({1'b0, 7'd12, 9'h1FF}, 16);
    send_bits({1'b0, 7'd10, 9'h1FF}, 16);
    send_bits({1'b0, 7'd100, 9'h1FF}, 16);
    check_bank("R9");
  endtask

  task automatic t_soft_reset();
    write_reg(7'd15, 9'h000);
    check_bank("R8");
    check("R8", 16'({hp_l_gain, hp_r_gain}), 16'({7'h79, 7'h79}));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #22 rst_ni = 1'b1;
    #20;
    t_reset();
    t_plain();
    t_linked_line();
    t_linked_hp();
    t_hp_boundary();
    t_bad_frames();
    t_unmapped();
    t_soft_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule